// File: doc/BRIEF.md
# Four-Channel Strided Stream Prefetcher

This block turns software prefetch hints into a stream of cacheline touch requests for a cache. It keeps four independent stream channels. A command names one channel with a 2-bit ID. A start command gives that channel a byte address, a block length in 32-byte lines, a block count and a signed byte stride between block starts. From these the channel walks block after block and produces one aligned line address at a time.

A round-robin arbiter merges the active channels onto a single valid/ready request port. Each request carries the channel that produced it, a store-intent flag and a transient flag. A transient request asks that the line be filled into the first-level cache only. A channel can be stopped on its own, or all channels can be stopped at once. A new start on a busy channel drops the old stream and begins the new one. A channel goes idle by itself after its last line is accepted, or once it has issued 4096 lines (128 KB).

Top module: `stream_prefetch`

## Requirements
- R1: After reset no channel is busy (`busy`=0) and `req_valid` is low.
- R2: A start (`cmd_op` bit 2 = 0) loads the channel. Its first request is the start address with bits [4:0] cleared. Each further line inside a block is 32 bytes above the previous one, for `cmd_size` lines per block.
- R3: Block k begins at (start address + k × sign-extended `cmd_stride`) with bits [4:0] cleared. This holds for positive and negative strides, for `cmd_count` blocks.
- R4: Start op bit 1 selects store intent and op bit 0 selects transient. So 000 is load, 001 is load transient, 010 is store and 011 is store transient. Every request of that stream carries these bits on `req_store` and `req_transient`.
- R5: A start on a busy channel discards the old stream. The next request from that channel comes from the new address with the new hints.
- R6: Stop-one (`cmd_op`=100) makes the named channel idle in the next cycle. Other channels are not affected.
- R7: Stop-all (`cmd_op`=101) makes every channel idle in the next cycle.
- R8: Among busy channels, grants rotate. After channel c is accepted, the search starts at channel c+1 (mod 4). `req_chan` always names a busy channel.
- R9: While `req_valid` is high and `req_ready` is low, and no command arrives, the request fields stay unchanged.
- R10: A channel clears its `busy` bit in the cycle after its final line request is accepted.
- R11: A stream ends after 4096 accepted lines (128 KB), even if its size and count ask for more.
- R12: A start whose size or count is zero leaves the channel idle. Op codes 110 and 111 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code (start variants, stop-one, stop-all) |
| cmd_chan | input | 2 | Channel ID |
| cmd_addr | input | ADDR_W | Start byte address |
| cmd_size | input | SIZE_W | Lines per block |
| cmd_count | input | CNT_W | Number of blocks |
| cmd_stride | input | STRIDE_W | Signed byte stride between block starts |
| req_valid | output | 1 | Line request present |
| req_ready | input | 1 | Cache accepts the request |
| req_addr | output | ADDR_W | 32-byte aligned line address |
| req_chan | output | 2 | Channel that owns the request |
| req_store | output | 1 | Store intent |
| req_transient | output | 1 | Fill first-level cache only |
| busy | output | 4 | Per-channel active flags |

## Verification
The first pattern is a single channel with a short block, which checks the walk inside a block and the return to idle. Multi-block streams with positive and negative strides then separate base stepping from line stepping. All four channels run with different hints, first with `req_ready` held high to expose the rotation order, then with a pseudo-random `req_ready`, which shows whether a stalled request holds and whether the pointer moves only on acceptance. Restart, stop-one, stop-all, zero-length starts, unused op codes and a single stream running past the 4096-line cap complete the set. Every cycle is compared against a behavioural model.

// File: rtl/stream_prefetch.sv
module stream_prefetch #(
  parameter int ADDR_W    = 32,
  parameter int SIZE_W    = 6,
  parameter int CNT_W     = 8,
  parameter int STRIDE_W  = 20,
  parameter int MAX_LINES = 4096
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic [2:0]          cmd_op,
  input  logic [1:0]          cmd_chan,
  input  logic [ADDR_W-1:0]   cmd_addr,
  input  logic [SIZE_W-1:0]   cmd_size,
  input  logic [CNT_W-1:0]    cmd_count,
  input  logic [STRIDE_W-1:0] cmd_stride,
  output logic                req_valid,
  input  logic                req_ready,
  output logic [ADDR_W-1:0]   req_addr,
  output logic [1:0]          req_chan,
  output logic                req_store,
  output logic                req_transient,
  output logic [3:0]          busy
);
  localparam int NCH   = 4;
  localparam int CH_W  = 2;
  localparam int TOT_W = $clog2(MAX_LINES + 1);
  localparam logic [ADDR_W-1:0] LINE_MASK = ~ADDR_W'(31);
  localparam logic [ADDR_W-1:0] LINE_STEP = ADDR_W'(32);
  localparam logic [2:0] OP_STOP    = 3'b100;
  localparam logic [2:0] OP_STOPALL = 3'b101;

  logic [NCH-1:0]                act, st, tr;
  logic [NCH-1:0][ADDR_W-1:0]    base, cur, nbase;
  logic [NCH-1:0][SIZE_W-1:0]    lidx, lsz;
  logic [NCH-1:0][CNT_W-1:0]     bidx, bcnt;
  logic [NCH-1:0][STRIDE_W-1:0]  strd;
  logic [NCH-1:0][TOT_W-1:0]     tot;
  logic [NCH-1:0]                last_line, last_blk, capped;
  logic [CH_W-1:0]               ptr, gnt;
  logic                          found, take;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      nbase[c]     = base[c] + {{(ADDR_W-STRIDE_W){strd[c][STRIDE_W-1]}}, strd[c]};
      last_line[c] = (lidx[c] == lsz[c] - SIZE_W'(1));
      last_blk[c]  = (bidx[c] == bcnt[c] - CNT_W'(1));
      capped[c]    = (tot[c] == TOT_W'(MAX_LINES - 1));
    end
  end

  always_comb begin
    gnt   = '0;
    found = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (!found && act[CH_W'(ptr + CH_W'(i))]) begin
        gnt   = CH_W'(ptr + CH_W'(i));
        found = 1'b1;
      end
    end
  end

  assign req_valid     = |act;
  assign take          = req_valid && req_ready;
  assign req_addr      = cur[gnt];
  assign req_chan      = gnt;
  assign req_store     = st[gnt];
  assign req_transient = tr[gnt];
  assign busy          = act;

  always_ff @(posedge clk) begin
    if (!rst_n) ptr <= '0;
    else if (take) ptr <= gnt + CH_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act <= '0; st <= '0; tr <= '0;
      base <= '0; cur <= '0; lidx <= '0; lsz <= '0;
      bidx <= '0; bcnt <= '0; strd <= '0; tot <= '0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (cmd_valid && cmd_op == OP_STOPALL) begin
          act[c] <= 1'b0;
        end else if (cmd_valid && cmd_chan == CH_W'(c) && cmd_op == OP_STOP) begin
          act[c] <= 1'b0;
        end else if (cmd_valid && cmd_chan == CH_W'(c) && !cmd_op[2]) begin
          act[c]  <= (cmd_size != '0) && (cmd_count != '0);
          st[c]   <= cmd_op[1];
          tr[c]   <= cmd_op[0];
          base[c] <= cmd_addr;
          cur[c]  <= cmd_addr & LINE_MASK;
          lsz[c]  <= cmd_size;
          bcnt[c] <= cmd_count;
          strd[c] <= cmd_stride;
          lidx[c] <= '0;
          bidx[c] <= '0;
          tot[c]  <= '0;
        end else if (take && gnt == CH_W'(c)) begin
          tot[c] <= tot[c] + TOT_W'(1);
          if (capped[c]) begin
            act[c] <= 1'b0;
          end else if (!last_line[c]) begin
            cur[c]  <= cur[c] + LINE_STEP;
            lidx[c] <= lidx[c] + SIZE_W'(1);
          end else if (!last_blk[c]) begin
            base[c] <= nbase[c];
            cur[c]  <= nbase[c] & LINE_MASK;
            lidx[c] <= '0;
            bidx[c] <= bidx[c] + CNT_W'(1);
          end else begin
            act[c] <= 1'b0;
          end
        end
      end
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready && !cmd_valid |=> req_valid && $stable(req_addr) && $stable(req_chan));

  assert_grant_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> busy[req_chan]);

  assert_stop_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == OP_STOP |=> !busy[$past(cmd_chan)]);

  assert_stop_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == OP_STOPALL |=> busy == '0);

  assert_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_op[2] && cmd_size != '0 && cmd_count != '0 |=> busy[$past(cmd_chan)]);

  for (genvar g = 0; g < NCH; g++) begin : g_cap
    assert_cap_R11: assert property (@(posedge clk) disable iff (!rst_n)
      busy[g] |-> tot[g] < TOT_W'(MAX_LINES));
  end
endmodule

// File: tb/tb_stream_prefetch.sv
module tb_stream_prefetch;
  localparam int MAXL = 4096;
  logic        clk = 0, rst_n = 0;
  logic        cmd_valid = 0;
  logic [2:0]  cmd_op = 0;
  logic [1:0]  cmd_chan = 0;
  logic [31:0] cmd_addr = 0;
  logic [5:0]  cmd_size = 0;
  logic [7:0]  cmd_count = 0;
  logic [19:0] cmd_stride = 0;
  logic        req_ready = 1;
  logic        req_valid, req_store, req_transient;
  logic [31:0] req_addr;
  logic [1:0]  req_chan;
  logic [3:0]  busy;

  stream_prefetch dut (.clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_chan(cmd_chan), .cmd_addr(cmd_addr), .cmd_size(cmd_size), .cmd_count(cmd_count),
    .cmd_stride(cmd_stride), .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_chan(req_chan), .req_store(req_store), .req_transient(req_transient), .busy(busy));

  always #10 clk = ~clk;

  int errors = 0, checks = 0;
  string tag = "R1";
  bit rnd_ready = 0;
  logic [15:0] lfsr = 16'hACE1;

  bit          m_act[4], m_st[4], m_tr[4];
  logic [31:0] m_base[4];
  int          m_line[4], m_blk[4], m_tot[4], m_size[4], m_cnt[4], m_stride[4];
  int          m_ptr = 0;

  function automatic int pick();
    for (int i = 0; i < 4; i++) if (m_act[(m_ptr + i) % 4]) return (m_ptr + i) % 4;
    return -1;
  endfunction

  function automatic logic [31:0] line_of(int c);
    return ((m_base[c] & ~32'd31) + 32'(m_line[c] * 32));
  endfunction

  task automatic check(string what, logic [31:0] act_v, logic [31:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act_v, exp_v, $time);
    end
  endtask

  task automatic tick();
    int g;
    logic [3:0] eb;
    if (rnd_ready) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      req_ready = lfsr[0];
    end
    #2;
    g = pick();
    for (int c = 0; c < 4; c++) eb[c] = m_act[c];
    check("busy", 32'(busy), 32'(eb));
    check("req_valid", 32'(req_valid), 32'(g >= 0));
    if (g >= 0 && req_valid) begin
      check("req_chan", 32'(req_chan), 32'(g));
      check("req_addr", req_addr, line_of(g));
      check("req_store", 32'(req_store), 32'(m_st[g]));
      check("req_transient", 32'(req_transient), 32'(m_tr[g]));
    end
    if (g >= 0 && req_ready) begin
      m_tot[g]++;
      m_ptr = (g + 1) % 4;
      if (m_tot[g] == MAXL) m_act[g] = 0;
      else if (m_line[g] + 1 < m_size[g]) m_line[g]++;
      else if (m_blk[g] + 1 < m_cnt[g]) begin
        m_base[g] = m_base[g] + 32'(m_stride[g]);
        m_line[g] = 0; m_blk[g]++;
      end else m_act[g] = 0;
    end
    if (cmd_valid) begin
      if (cmd_op == 3'b101) for (int c = 0; c < 4; c++) m_act[c] = 0;
      else if (cmd_op == 3'b100) m_act[cmd_chan] = 0;
      else if (!cmd_op[2]) begin
        m_act[cmd_chan] = (cmd_size != 0) && (cmd_count != 0);
        m_st[cmd_chan] = cmd_op[1]; m_tr[cmd_chan] = cmd_op[0];
        m_base[cmd_chan] = cmd_addr; m_size[cmd_chan] = int'(cmd_size);
        m_cnt[cmd_chan] = int'(cmd_count); m_stride[cmd_chan] = int'($signed(cmd_stride));
        m_line[cmd_chan] = 0; m_blk[cmd_chan] = 0; m_tot[cmd_chan] = 0;
      end
    end
    @(negedge clk);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic cmd(logic [2:0] op, logic [1:0] ch, logic [31:0] a, int sz, int cn, int sd);
    cmd_valid = 1; cmd_op = op; cmd_chan = ch; cmd_addr = a;
    cmd_size = 6'(sz); cmd_count = 8'(cn); cmd_stride = 20'(sd);
    tick();
    cmd_valid = 0;
  endtask

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_up();
  end

  initial begin
    for (int c = 0; c < 4; c++) begin
      m_act[c] = 0; m_st[c] = 0; m_tr[c] = 0; m_base[c] = 0;
      m_line[c] = 0; m_blk[c] = 0; m_tot[c] = 0; m_size[c] = 0; m_cnt[c] = 0; m_stride[c] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R1"; run(3);
    tag = "R2"; cmd(3'b000, 2'd0, 32'h1007, 3, 1, 0); run(2);
    tag = "R10"; run(3);
    tag = "R3"; cmd(3'b010, 2'd1, 32'h8010, 2, 3, -256); run(8);
    cmd(3'b000, 2'd3, 32'h2000, 1, 4, 32'h1000); run(6);
    tag = "R4";
    cmd(3'b000, 2'd0, 32'h100, 2, 2, 64);
    cmd(3'b001, 2'd1, 32'h200, 2, 2, 64);
    cmd(3'b010, 2'd2, 32'h300, 2, 2, 64);
    cmd(3'b011, 2'd3, 32'h400, 2, 2, 64);
    tag = "R8"; run(20);
    tag = "R9"; rnd_ready = 1;
    cmd(3'b011, 2'd0, 32'h5000, 4, 3, 128);
    cmd(3'b010, 2'd2, 32'h9000, 3, 3, -96);
    run(80);
    rnd_ready = 0; req_ready = 1;
    tag = "R5"; cmd(3'b000, 2'd2, 32'hA000, 8, 8, 512); run(3);
    cmd(3'b011, 2'd2, 32'hC040, 2, 2, 64); run(6);
    tag = "R6";
    cmd(3'b000, 2'd0, 32'h10000, 10, 10, 1024);
    cmd(3'b010, 2'd1, 32'h20000, 10, 10, 1024); run(3);
    cmd(3'b100, 2'd0, 0, 0, 0, 0); run(5);
    tag = "R7";
    cmd(3'b001, 2'd2, 32'h30000, 10, 10, 64);
    cmd(3'b000, 2'd3, 32'h40000, 10, 10, 64); run(2);
    cmd(3'b101, 2'd0, 0, 0, 0, 0); run(3);
    tag = "R12";
    cmd(3'b000, 2'd0, 32'h500, 0, 4, 64); run(2);
    cmd(3'b000, 2'd1, 32'h600, 4, 0, 64); run(2);
    cmd(3'b000, 2'd2, 32'h700, 6, 2, 64); run(1);
    cmd(3'b110, 2'd2, 32'hFFF0, 1, 1, 0);
    cmd(3'b111, 2'd2, 32'hFFF0, 1, 1, 0); run(12);
    tag = "R11"; cmd(3'b000, 2'd1, 32'h100000, 63, 255, 4096); run(4110);
    finish_up();
  end
endmodule